// File: doc/BRIEF.md
# Programmable-Ratio Phase/Frequency Detector

This block sits in the digital half of an external-VCO clock loop. Two event streams arrive as single-cycle strobes in the system clock domain. One stream is the reference byte clock and the other is the feedback clock returned from the VCO. Each stream is counted down by its own programmable divider, and the divider's terminal count then flips a divide-by-two toggle, so that the detector works on two square waves of equal duty. The detector steers an external charge pump through a pump-up output and a pump-down output. The pump floats whenever both outputs are low.

A host programs the two divide ratios and one detector-mode bit through a small write port. In the acquisition mode the detector is a two-flop phase-frequency detector. A reference rising edge raises pump-up, a feedback rising edge raises pump-down, and the two flops are cleared together once both have been high for a fixed number of cycles. In the tracking mode the flops are held clear. The outputs then show the exclusive-or of the two toggles, split by which toggle is high, so only phase error is reported and no frequency steering takes place. A new ratio is queued and is only adopted at the end of the current divider period.

Top module: `ratio_pfd`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears both divider counts and both toggles, sets both active ratios and both queued ratios to 1, selects phase-frequency mode and clears the detector. Both pump outputs are low in the following cycle.
- R2: A divider with active ratio N reaches terminal count on every Nth strobe of its stream. Each terminal count flips that path's toggle, and the flip is visible in the cycle after the strobe.
- R3: A ratio value of 0 behaves exactly as a ratio of 1.
- R4: A ratio written to the write port is held in a queue and becomes active only at that divider's next terminal count. A write landing in the same cycle as a terminal count waits for the terminal count after it.
- R5: In phase-frequency mode, a toggle rising edge on the reference path raises `pump_up` in the cycle after the strobe, and on the feedback path it raises `pump_dn`. Each output stays high until the joint clear.
- R6: In phase-frequency mode, once both outputs are high they stay high together for exactly RST_PULSE cycles (default 2) and then both fall. The overlap never lasts longer.
- R7: If rising edges on both paths arrive in the same cycle as the joint clear, they cancel, and both outputs are low afterwards.
- R8: In phase-only mode, `pump_up` equals reference toggle AND NOT feedback toggle, and `pump_dn` equals feedback toggle AND NOT reference toggle. The two are never high together.
- R9: A mode write takes effect in the cycle after the write. Entering phase-only mode clears the detector flops, so that returning to phase-frequency mode starts with both outputs low.
- R10: Write decoding is as follows: `wr_addr` 0 queues the reference ratio from `wr_data[14:0]`; `wr_addr` 1 queues the feedback ratio from `wr_data[14:0]`; `wr_addr` 2 sets the mode from `wr_data[15]` (1 = phase-only). Address 3 and any write made while `rst` is high have no effect.
- R11: A reset asserted in the middle of operation returns both toggles to 0, so that the first strobe after reset raises the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 ref ratio, 1 fb ratio, 2 mode) |
| wr_data | input | 16 | Write data: ratio in [14:0], mode in [15] |
| ref_edge | input | 1 | One-cycle strobe per reference clock cycle |
| fb_edge | input | 1 | One-cycle strobe per feedback clock cycle |
| pump_up | output | 1 | Charge-pump source request |
| pump_dn | output | 1 | Charge-pump sink request |

## Verification
The critical collision is the detector's joint clear landing in the same cycle as fresh rising edges on one or both divided paths. A second collision is a ratio write arriving on the cycle of a terminal count. A directed sequence places a rising edge on both paths exactly on the clear cycle and expects both outputs low afterwards. Long runs of dense random strobes, small ratios and mid-run ratio and mode writes make both collisions recur many times. Every cycle is judged against a cycle-level model of the requirements, and a counter-based bound in the checker catches any over-long overlap.

// File: rtl/ratio_pfd_pkg.sv
package ratio_pfd_pkg;

  // Register selects on the host write port.
  typedef enum logic [1:0] {
    SEL_REF_RATIO = 2'd0,
    SEL_FB_RATIO  = 2'd1,
    SEL_MODE      = 2'd2,
    SEL_SPARE     = 2'd3
  } reg_sel_e;

  // Path indices used by the generate loop.
  localparam int PATH_REF = 0;
  localparam int PATH_FB  = 1;
  localparam int N_PATHS  = 2;

endpackage

// File: rtl/ratio_pfd_regs.sv
module ratio_pfd_regs
  import ratio_pfd_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W:0]   wr_data,
  output logic [DIV_W-1:0] ref_ratio_q,
  output logic [DIV_W-1:0] fb_ratio_q,
  output logic             ph_mode_q
);

  localparam logic [DIV_W-1:0] RATIO_RST = DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_ratio_q <= RATIO_RST;
      fb_ratio_q  <= RATIO_RST;
      ph_mode_q   <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        SEL_REF_RATIO: ref_ratio_q <= wr_data[DIV_W-1:0];
        SEL_FB_RATIO:  fb_ratio_q  <= wr_data[DIV_W-1:0];
        SEL_MODE:      ph_mode_q   <= wr_data[DIV_W];
        default:       ;
      endcase
    end
  end

endmodule

// File: rtl/ratio_pfd_div.sv
module ratio_pfd_div #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_i,
  input  logic [DIV_W-1:0] queued_i,
  output logic             tc_o,
  output logic             rise_o,
  output logic             tog_o,
  output logic [DIV_W-1:0] lim_o
);

  // Ratio 0 is mapped to 1 so the limit is never zero.
  function automatic logic [DIV_W-1:0] eff_limit(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  // Last count value of a period for a given limit.
  function automatic logic [DIV_W-1:0] last_count(input logic [DIV_W-1:0] lim);
    return lim - DIV_W'(1);
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim_q;
  logic             tog_q;

  assign tc_o   = edge_i && (cnt_q == last_count(lim_q));
  assign rise_o = tc_o && !tog_q;
  assign tog_o  = tog_q;
  assign lim_o  = lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= DIV_W'(1);
      tog_q <= 1'b0;
    end else if (tc_o) begin
      cnt_q <= '0;
      lim_q <= eff_limit(queued_i);
      tog_q <= !tog_q;
    end else if (edge_i) begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/ratio_pfd_det.sv
module ratio_pfd_det #(
  parameter int RST_PULSE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ph_mode,
  input  logic rise_ref,
  input  logic rise_fb,
  input  logic tog_ref,
  input  logic tog_fb,
  output logic clr_o,
  output logic pump_up,
  output logic pump_dn
);

  localparam int RC_W = (RST_PULSE < 2) ? 1 : $clog2(RST_PULSE);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_PULSE - 1);

  logic            up_q, dn_q;
  logic [RC_W-1:0] rc_q;
  logic            both;
  logic            cancel;

  assign both   = up_q && dn_q;
  assign clr_o  = both && (rc_q == RC_LAST);
  assign cancel = clr_o && rise_ref && rise_fb;

  always_ff @(posedge clk) begin
    if (rst || ph_mode) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      rc_q <= '0;
    end else begin
      if (cancel) begin
        up_q <= 1'b0;
        dn_q <= 1'b0;
      end else begin
        up_q <= (up_q && !clr_o) || rise_ref;
        dn_q <= (dn_q && !clr_o) || rise_fb;
      end
      rc_q <= (both && !clr_o) ? rc_q + RC_W'(1) : '0;
    end
  end

  always_comb begin
    if (ph_mode) begin
      pump_up = tog_ref && !tog_fb;
      pump_dn = tog_fb && !tog_ref;
    end else begin
      pump_up = up_q;
      pump_dn = dn_q;
    end
  end

endmodule

// File: rtl/ratio_pfd.sv
module ratio_pfd
  import ratio_pfd_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int RST_PULSE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DIV_W:0]   wr_data,
  input  logic             ref_edge,
  input  logic             fb_edge,
  output logic             pump_up,
  output logic             pump_dn
);

  logic [DIV_W-1:0] queued [N_PATHS];
  logic [DIV_W-1:0] lim_arr [N_PATHS];
  logic [N_PATHS-1:0] edge_vec, tc_vec, rise_vec, tog_vec;
  logic             mode_ph;
  logic             clr_ev;

  // Named events for the checker.
  logic             tc_ref, tog_ref;
  logic [DIV_W-1:0] lim_ref, lim_fb;

  assign edge_vec[PATH_REF] = ref_edge;
  assign edge_vec[PATH_FB]  = fb_edge;

  ratio_pfd_regs #(.DIV_W(DIV_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .ref_ratio_q (queued[PATH_REF]),
    .fb_ratio_q  (queued[PATH_FB]),
    .ph_mode_q   (mode_ph)
  );

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    ratio_pfd_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst      (rst),
      .edge_i   (edge_vec[p]),
      .queued_i (queued[p]),
      .tc_o     (tc_vec[p]),
      .rise_o   (rise_vec[p]),
      .tog_o    (tog_vec[p]),
      .lim_o    (lim_arr[p])
    );
  end

  ratio_pfd_det #(.RST_PULSE(RST_PULSE)) u_det (
    .clk      (clk),
    .rst      (rst),
    .ph_mode  (mode_ph),
    .rise_ref (rise_vec[PATH_REF]),
    .rise_fb  (rise_vec[PATH_FB]),
    .tog_ref  (tog_vec[PATH_REF]),
    .tog_fb   (tog_vec[PATH_FB]),
    .clr_o    (clr_ev),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn)
  );

  assign tc_ref  = tc_vec[PATH_REF];
  assign tog_ref = tog_vec[PATH_REF];
  assign lim_ref = lim_arr[PATH_REF];
  assign lim_fb  = lim_arr[PATH_FB];

endmodule

// File: rtl/ratio_pfd_chk.sv
module ratio_pfd_chk #(
  parameter int DIV_W     = 15,
  parameter int RST_PULSE = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             pump_up,
  input logic             pump_dn,
  input logic             mode_ph,
  input logic             clr_ev,
  input logic             tc_ref,
  input logic             tog_ref,
  input logic [DIV_W-1:0] lim_ref,
  input logic [DIV_W-1:0] lim_fb
);

  localparam int OV_W = $clog2(RST_PULSE + 2);
  logic [OV_W-1:0] ov_q;

  // Consecutive cycles with both pump outputs high, saturating.
  always_ff @(posedge clk) begin
    if (rst) ov_q <= '0;
    else if (pump_up && pump_dn) ov_q <= (ov_q == '1) ? ov_q : ov_q + OV_W'(1);
    else ov_q <= '0;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!pump_up && !pump_dn));

  a_r2_toggle_on_tc: assert property (@(posedge clk) disable iff (rst)
    tc_ref |=> (tog_ref != $past(tog_ref)));

  a_r2_toggle_hold: assert property (@(posedge clk) disable iff (rst)
    !tc_ref |=> $stable(tog_ref));

  a_r3_limit_nonzero: assert property (@(posedge clk) disable iff (rst)
    (lim_ref != '0) && (lim_fb != '0));

  a_r4_limit_only_at_tc: assert property (@(posedge clk) disable iff (rst)
    !tc_ref |=> $stable(lim_ref));

  a_r5_up_held: assert property (@(posedge clk) disable iff (rst)
    (!mode_ph && pump_up && !clr_ev) |=> (pump_up || mode_ph));

  a_r6_overlap_bound: assert property (@(posedge clk) disable iff (rst)
    (pump_up && pump_dn) |-> (ov_q < OV_W'(RST_PULSE)));

  a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
    mode_ph |-> !(pump_up && pump_dn));

endmodule

bind ratio_pfd ratio_pfd_chk #(.DIV_W(DIV_W), .RST_PULSE(RST_PULSE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pump_up (pump_up),
  .pump_dn (pump_dn),
  .mode_ph (mode_ph),
  .clr_ev  (clr_ev),
  .tc_ref  (tc_ref),
  .tog_ref (tog_ref),
  .lim_ref (lim_ref),
  .lim_fb  (lim_fb)
);

// File: tb/test_ratio_pfd.sv
`timescale 1ns/1ps
module test_ratio_pfd;
  localparam int DIV_W = 15;
  localparam int RP    = 2;
  localparam logic [DIV_W:0] MODE_PH  = 16'h8000;
  localparam logic [DIV_W:0] MODE_PFD = 16'h0000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = 2'd0;
  logic [DIV_W:0]   wr_data = '0;
  logic             ref_edge = 1'b0;
  logic             fb_edge = 1'b0;
  logic             pump_up, pump_dn;

  int  checks = 0;
  int  fails = 0;
  bit  cmp_on = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  ratio_pfd #(.DIV_W(DIV_W), .RST_PULSE(RP)) i_ratio_pfd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ref_edge(ref_edge), .fb_edge(fb_edge), .pump_up(pump_up), .pump_dn(pump_dn)
  );

  // ---------------- cycle model built from the requirements ----------------
  logic [DIV_W-1:0] m_q[2], m_lim[2], m_cnt[2];
  logic             m_tog[2];
  logic             m_up, m_dn, m_mode;
  int               m_rc;

  function automatic logic [DIV_W-1:0] as_ratio(input logic [DIV_W-1:0] v);
    if (v == 0) return 1;
    return v;
  endfunction

  always @(posedge clk) begin : model
    logic st[2];
    logic hit[2];
    logic up_edge[2];
    logic both, clear;
    st[0] = ref_edge;
    st[1] = fb_edge;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_q[i] = 1; m_lim[i] = 1; m_cnt[i] = 0; m_tog[i] = 1'b0;
      end
      m_up = 1'b0; m_dn = 1'b0; m_rc = 0; m_mode = 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        hit[i]     = st[i] && (int'(m_cnt[i]) + 1 == int'(m_lim[i]));
        up_edge[i] = hit[i] && !m_tog[i];
      end
      if (m_mode) begin
        m_up = 1'b0; m_dn = 1'b0; m_rc = 0;
      end else begin
        both  = m_up && m_dn;
        clear = both && (m_rc == RP - 1);
        if (clear && up_edge[0] && up_edge[1]) begin
          m_up = 1'b0; m_dn = 1'b0;
        end else begin
          m_up = (m_up && !clear) || up_edge[0];
          m_dn = (m_dn && !clear) || up_edge[1];
        end
        m_rc = (both && !clear) ? m_rc + 1 : 0;
      end
      for (int i = 0; i < 2; i++) begin
        if (hit[i]) begin
          m_cnt[i] = 0; m_tog[i] = !m_tog[i]; m_lim[i] = as_ratio(m_q[i]);
        end else if (st[i]) begin
          m_cnt[i] = m_cnt[i] + 1;
        end
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_q[0] = wr_data[DIV_W-1:0];
          2'd1: m_q[1] = wr_data[DIV_W-1:0];
          2'd2: m_mode = wr_data[DIV_W];
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic expect2(input string tag, input logic eu, input logic ed);
    checks++;
    if (pump_up !== eu || pump_dn !== ed) begin
      fails++;
      $display("FAIL %s: up/dn actual=%b%b expected=%b%b at %0t", tag, pump_up, pump_dn, eu, ed, $time);
    end
  endtask

  // Drive one cycle from a falling edge; return at the next falling edge.
  task automatic cyc(input logic r, input logic f, input logic we,
                     input logic [1:0] a, input logic [DIV_W:0] d, input logic rs);
    ref_edge = r; fb_edge = f; wr_en = we; wr_addr = a; wr_data = d; rst = rs;
    @(negedge clk);
    if (cmp_on) begin
      if (m_mode) expect2("R8 model", m_tog[0] && !m_tog[1], m_tog[1] && !m_tog[0]);
      else        expect2("R6 model", m_up, m_dn);
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 2'd0, '0, 0);
  endtask

  task automatic do_reset();
    cyc(0, 0, 0, 2'd0, '0, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(); do_reset();
    expect2("R1 reset", 0, 0);

    // R2 / R4: reference ratio 3 in phase-only mode
    cyc(0, 0, 1, 2'd0, 16'd3, 0);
    cyc(0, 0, 1, 2'd2, MODE_PH, 0);
    expect2("R8 idle", 0, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R4 old ratio used", 1, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R2 count 1", 1, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R2 count 2", 1, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R2 third strobe", 0, 0);

    // R3: feedback ratio 0 acts as 1
    cyc(0, 0, 1, 2'd1, 16'd0, 0);
    cyc(0, 1, 0, 2'd0, '0, 0); expect2("R3 strobe a", 0, 1);
    cyc(0, 1, 0, 2'd0, '0, 0); expect2("R3 strobe b", 0, 0);
    cyc(0, 1, 0, 2'd0, '0, 0); expect2("R3 strobe c", 0, 1);

    // R5 / R6: phase-frequency pulses and joint clear
    do_reset();
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R5 up set", 1, 0);
    idle();                    expect2("R5 up held", 1, 0);
    cyc(0, 1, 0, 2'd0, '0, 0); expect2("R6 overlap 1", 1, 1);
    idle();                    expect2("R6 overlap 2", 1, 1);
    idle();                    expect2("R6 cleared", 0, 0);

    // R7: coincident rises on the clear cycle cancel
    do_reset();
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R7 setup a", 1, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R7 setup b", 1, 0);
    cyc(0, 1, 0, 2'd0, '0, 0); expect2("R7 setup c", 1, 1);
    cyc(0, 1, 0, 2'd0, '0, 0); expect2("R7 setup d", 1, 1);
    cyc(1, 1, 0, 2'd0, '0, 0); expect2("R7 cancel", 0, 0);

    // R10: write during reset and spare address ignored
    cyc(0, 0, 1, 2'd0, 16'd5, 1);
    cyc(0, 0, 1, 2'd3, MODE_PH, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R10 pfd kept a", 1, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R10 pfd kept b", 1, 0);
    cyc(0, 0, 1, 2'd2, MODE_PH, 0); expect2("R10 mode write", 0, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R10 ratio still 1 a", 1, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R10 ratio still 1 b", 0, 0);
    cyc(1, 0, 0, 2'd0, '0, 0); expect2("R10 ratio still 1 c", 1, 0);

    // R9: entering phase-only clears the detector flops
    do_reset();
    cyc(1, 0, 0, 2'd0, '0, 0);       expect2("R9 pfd up", 1, 0);
    cyc(0, 0, 1, 2'd2, MODE_PH, 0);  expect2("R9 phase view", 1, 0);
    cyc(1, 0, 0, 2'd0, '0, 0);       expect2("R9 phase fall", 0, 0);
    cyc(0, 0, 1, 2'd2, MODE_PFD, 0); expect2("R9 back to pfd", 0, 0);

    // R11: mid-run reset returns toggles to 0
    cyc(1, 0, 0, 2'd0, '0, 0);       expect2("R11 before reset", 1, 0);
    do_reset();                      expect2("R11 after reset", 0, 0);
    cyc(0, 0, 1, 2'd2, MODE_PH, 0);  expect2("R11 toggle cleared", 0, 0);
    cyc(1, 0, 0, 2'd0, '0, 0);       expect2("R11 first strobe rises", 1, 0);

    // Random phase compared with the model every cycle
    do_reset();
    cmp_on = 1'b1;
    for (int n = 0; n < 6000; n++) begin
      logic r, f, we, rs;
      logic [1:0] a;
      logic [DIV_W:0] d;
      r  = ($urandom % 100) < 55;
      f  = ($urandom % 100) < 55;
      we = ($urandom % 100) < 6;
      a  = 2'($urandom % 4);
      d  = (a == 2'd2) ? (($urandom % 100) < 50 ? MODE_PH : MODE_PFD)
                       : (DIV_W+1)'($urandom % 5);
      rs = ($urandom % 1000) < 3;
      cyc(r, f, we, a, d, rs);
    end
    cmp_on = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule